// File: doc/BRIEF.md
# Touch-Screen Converter Serial Host

This block is the host-side master that runs conversions on a serial touch-screen analog-to-digital converter. A request carries a channel code, a resolution choice (12-bit or 8-bit), a reference-mode choice and a two-bit power-down code. The block packs them into an eight-bit command, lowers chip select, and generates a serial clock from the system clock through a parameterised divider. It sends the command most significant bit first, captures the converter's reply bit by bit, and hands back the value with a one-cycle done pulse.

Two framings exist. In the standard framing every conversion is a 24-clock frame inside one chip-select window. With overlap enabled, one further request may be queued while a frame runs. The next command then begins on serial clock 16 of the running frame for a 12-bit conversion, or on clock 12 for an 8-bit one. Chip select stays low, and the reply of the earlier conversion is still gathered while the new command goes out.

The controller has four states. ST_IDLE launches a queued command on a divider tick: chip select falls, the start bit goes out, and the state moves to ST_LOW. ST_LOW waits half a period and raises the serial clock, which moves to ST_HIGH. From ST_HIGH, the falling edge returns to ST_LOW. There are two exceptions. If overlap is enabled, a command is queued and the position equals the overlap point, the next command is relaunched and the state returns to ST_LOW. If the position equals 24, the state moves to ST_END. ST_END raises chip select half a period later and returns to ST_IDLE.

Top module: `touch_adc_host`

## Requirements
- R1: The command is sent on `din` most significant bit first as {1, chan[2:0], narrow, ref_single, pd[1:0]}. Bit 7 is the start bit and is always 1. `din` changes only while `dclk` is low, and it is 0 after the eighth bit.
- R2: Chip select falls while `dclk` is low. The first `dclk` rise follows DCLK_HALF system clocks later. `dclk` is high only while `cs_n` is low.
- R3: A standard frame has exactly 24 `dclk` rises between the fall and the rise of `cs_n`.
- R4: With narrow=0, the reply bits are taken on `dclk` rises 10 to 21, counted from the command's start bit, most significant bit first. The 12-bit value appears on `result` together with a `done` pulse one system clock long.
- R5: With narrow=1, the reply bits are taken on rises 10 to 17. The value is returned right-aligned, with `result[11:8]` equal to 0.
- R6: `busy` is high from an accepted request until its frame ends. With overlap_en=0, a request made while `busy` is high is ignored.
- R7: With overlap_en=1, one request made while `busy` is high is queued. Further requests are ignored until that queued request launches.
- R8: With overlap_en=1 and a request queued, the next start bit goes out on rise 16 of a 12-bit frame, or on rise 12 of an 8-bit frame. `cs_n` stays low, both results are returned, and the whole window is 15 or 11 rises plus 24.
- R9: During and after reset, `cs_n` is 1 and `dclk`, `din`, `busy` and `done` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req | input | 1 | Conversion request, one-cycle pulse |
| chan | input | 3 | Channel select code |
| narrow | input | 1 | 1 = 8-bit conversion, 0 = 12-bit |
| ref_single | input | 1 | 1 = single-ended reference, 0 = ratiometric |
| pd | input | 2 | Power-down code |
| overlap_en | input | 1 | Enables overlapped back-to-back commands |
| busy | output | 1 | A request is pending or a frame is running |
| done | output | 1 | One-cycle pulse, result valid |
| result | output | 12 | Converted value, right-aligned |
| cs_n | output | 1 | Converter chip select, active low |
| dclk | output | 1 | Serial clock to the converter |
| din | output | 1 | Serial command to the converter |
| dout | input | 1 | Serial reply from the converter |

## Verification
With overlap enabled, the command shifter and the reply capture run in the same serial clocks. The new start bit and command bits go out on `din` during the same rises on which the last reply bits of the earlier conversion are taken from `dout`. The bench provokes this by queuing a second request right after the first frame opens. It judges the outcome with a converter model that decodes each command from `din` and answers with a value derived from that command. Both results must match, the start bits must be 15 or 11 rises apart, and a third request made while the second is still queued must never reach the wire.

// File: rtl/touch_adc_pkg.sv
package touch_adc_pkg;

    localparam int CTRL_BITS   = 8;
    localparam int FRAME_CLKS  = 24;
    localparam int RES_FIRST   = 10;
    localparam int SLOT_WIDE   = 15;
    localparam int SLOT_NARROW = 11;
    localparam int RES_WIDE    = 12;
    localparam int RES_NARROW  = 8;
    localparam int POS_W       = $clog2(FRAME_CLKS + 1);

    typedef struct packed {
        logic [2:0] chan;
        logic       narrow;
        logic       ref_single;
        logic [1:0] pd;
    } adc_cmd_t;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_LOW,
        ST_HIGH,
        ST_END
    } host_state_e;

    function automatic logic [CTRL_BITS-1:0] ctrl_byte(adc_cmd_t c);
        return {1'b1, c.chan, c.narrow, c.ref_single, c.pd};
    endfunction

endpackage

// File: rtl/touch_adc_tick.sv
module touch_adc_tick #(
    parameter int HALF = 2
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick
);
    localparam int CW = (HALF > 1) ? $clog2(HALF) : 1;

    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt  <= '0;
            tick <= 1'b0;
        end else if (cnt == CW'(HALF - 1)) begin
            cnt  <= '0;
            tick <= 1'b1;
        end else begin
            cnt  <= cnt + CW'(1);
            tick <= 1'b0;
        end
    end

endmodule

// File: rtl/touch_adc_rx.sv
module touch_adc_rx
    import touch_adc_pkg::*;
#(
    parameter int W = RES_WIDE
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         sample,
    input  logic         first,
    input  logic         narrow_i,
    input  logic         bit_i,
    output logic         done,
    output logic [W-1:0] data
);
    localparam int CW = $clog2(W + 1);

    logic          active;
    logic          narrow_q;
    logic [CW-1:0] cnt;
    logic [CW-1:0] cnt_n;
    logic [CW-1:0] len;
    logic [W-1:0]  sr;
    logic [W-1:0]  sr_n;

    assign sr_n  = {sr[W-2:0], bit_i};
    assign cnt_n = cnt + CW'(1);
    assign len   = narrow_q ? CW'(RES_NARROW) : CW'(W);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active   <= 1'b0;
            narrow_q <= 1'b0;
            cnt      <= '0;
            sr       <= '0;
            done     <= 1'b0;
            data     <= '0;
        end else begin
            done <= 1'b0;
            if (sample && first) begin
                sr       <= sr_n;
                cnt      <= CW'(1);
                active   <= 1'b1;
                narrow_q <= narrow_i;
            end else if (sample && active) begin
                sr  <= sr_n;
                cnt <= cnt_n;
                if (cnt_n == len) begin
                    done   <= 1'b1;
                    active <= 1'b0;
                    data   <= narrow_q ? W'(sr_n[RES_NARROW-1:0]) : sr_n;
                end
            end
        end
    end

endmodule

// File: rtl/touch_adc_slot.sv
module touch_adc_slot
    import touch_adc_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     push,
    input  adc_cmd_t push_cmd,
    input  logic     pop,
    output logic     valid,
    output adc_cmd_t cmd
);
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid <= 1'b0;
            cmd   <= '0;
        end else if (push) begin
            valid <= 1'b1;
            cmd   <= push_cmd;
        end else if (pop) begin
            valid <= 1'b0;
        end
    end

endmodule

// File: rtl/touch_adc_host.sv
module touch_adc_host
    import touch_adc_pkg::*;
#(
    parameter int DCLK_HALF = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                req,
    input  logic [2:0]          chan,
    input  logic                narrow,
    input  logic                ref_single,
    input  logic [1:0]          pd,
    input  logic                overlap_en,
    output logic                busy,
    output logic                done,
    output logic [RES_WIDE-1:0] result,
    output logic                cs_n,
    output logic                dclk,
    output logic                din,
    input  logic                dout
);
    host_state_e state, state_n;

    logic                 tick;
    logic [POS_W-1:0]     pos;
    logic [POS_W-1:0]     pos_inc;
    logic [POS_W-1:0]     slot;
    adc_cmd_t             cur;
    adc_cmd_t             q_cmd;
    adc_cmd_t             req_cmd;
    logic                 q_valid;
    logic                 push;
    logic                 pop;
    logic                 launch;
    logic                 relaunch;
    logic                 sample;
    logic                 first;
    logic [CTRL_BITS-1:0] cur_byte;
    logic [CTRL_BITS-1:0] q_byte;

    touch_adc_tick #(.HALF(DCLK_HALF)) u_tick (
        .clk  (clk),
        .rst_n(rst_n),
        .tick (tick)
    );

    assign req_cmd  = '{chan: chan, narrow: narrow, ref_single: ref_single, pd: pd};
    assign push     = req && !q_valid && (state == ST_IDLE || overlap_en);
    assign pos_inc  = pos + POS_W'(1);
    assign slot     = cur.narrow ? POS_W'(SLOT_NARROW) : POS_W'(SLOT_WIDE);
    assign launch   = (state == ST_IDLE) && tick && q_valid;
    assign relaunch = (state == ST_HIGH) && tick && overlap_en && q_valid && (pos == slot);
    assign pop      = launch || relaunch;
    assign sample   = (state == ST_LOW) && tick;
    assign first    = sample && (pos_inc == POS_W'(RES_FIRST));
    assign cur_byte = ctrl_byte(cur);
    assign q_byte   = ctrl_byte(q_cmd);
    assign busy     = (state != ST_IDLE) || q_valid;

    touch_adc_slot u_slot (
        .clk     (clk),
        .rst_n   (rst_n),
        .push    (push),
        .push_cmd(req_cmd),
        .pop     (pop),
        .valid   (q_valid),
        .cmd     (q_cmd)
    );

    touch_adc_rx #(.W(RES_WIDE)) u_rx (
        .clk     (clk),
        .rst_n   (rst_n),
        .sample  (sample),
        .first   (first),
        .narrow_i(cur.narrow),
        .bit_i   (dout),
        .done    (done),
        .data    (result)
    );

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE;
        end else begin
            state <= state_n;
        end
    end

    // Transitions
    always_comb begin
        state_n = state;
        unique case (state)
            ST_IDLE: if (launch) state_n = ST_LOW;
            ST_LOW:  if (tick) state_n = ST_HIGH;
            ST_HIGH: begin
                if (tick) begin
                    if (relaunch) begin
                        state_n = ST_LOW;
                    end else if (pos == POS_W'(FRAME_CLKS)) begin
                        state_n = ST_END;
                    end else begin
                        state_n = ST_LOW;
                    end
                end
            end
            ST_END:  if (tick) state_n = ST_IDLE;
            default: state_n = ST_IDLE;
        endcase
    end

    // Pins and frame position
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cs_n <= 1'b1;
            dclk <= 1'b0;
            din  <= 1'b0;
            pos  <= '0;
            cur  <= '0;
        end else if (tick) begin
            unique case (state)
                ST_IDLE: begin
                    if (q_valid) begin
                        cs_n <= 1'b0;
                        din  <= q_byte[CTRL_BITS-1];
                        cur  <= q_cmd;
                        pos  <= '0;
                    end
                end
                ST_LOW: begin
                    dclk <= 1'b1;
                    pos  <= pos_inc;
                end
                ST_HIGH: begin
                    dclk <= 1'b0;
                    if (relaunch) begin
                        din <= q_byte[CTRL_BITS-1];
                        cur <= q_cmd;
                        pos <= '0;
                    end else if (pos < POS_W'(CTRL_BITS)) begin
                        din <= cur_byte[3'd7 - pos[2:0]];
                    end else begin
                        din <= 1'b0;
                    end
                end
                ST_END: begin
                    cs_n <= 1'b1;
                end
                default: cs_n <= 1'b1;
            endcase
        end
    end

endmodule

// File: rtl/touch_adc_host_chk.sv
module touch_adc_host_chk (
    input logic clk,
    input logic rst_n,
    input logic cs_n,
    input logic dclk,
    input logic din,
    input logic busy,
    input logic done
);
    // R2
    dclk_in_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dclk |-> !cs_n);

    // R1
    din_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (dclk && $past(dclk)) |-> $stable(din));

    // R1
    start_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(cs_n) |-> din);

    // R4
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R6
    idle_cs_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> cs_n);

endmodule

bind touch_adc_host touch_adc_host_chk u_chk (
    .clk  (clk),
    .rst_n(rst_n),
    .cs_n (cs_n),
    .dclk (dclk),
    .din  (din),
    .busy (busy),
    .done (done)
);

// File: tb/touch_adc_host_test.sv
`timescale 1ns/1ps
module touch_adc_host_test;

    localparam int HALF = 2;
    // {chan, narrow, ref_single, pd}
    localparam logic [6:0] VEC [0:5] = '{
        7'b000_0_0_00, 7'b101_1_1_11, 7'b011_0_1_01,
        7'b110_1_0_10, 7'b111_0_0_11, 7'b001_1_1_00
    };

    logic        clk = 0, rst_n = 0, req = 0, narrow = 0, ref_single = 0, overlap_en = 0;
    logic [2:0]  chan = 0;
    logic [1:0]  pd = 0;
    logic        busy, done, cs_n, dclk, din;
    logic        dout = 0;
    logic [11:0] result;

    touch_adc_host #(.DCLK_HALF(HALF)) uut (
        .clk(clk), .rst_n(rst_n), .req(req), .chan(chan), .narrow(narrow),
        .ref_single(ref_single), .pd(pd), .overlap_en(overlap_en), .busy(busy),
        .done(done), .result(result), .cs_n(cs_n), .dclk(dclk), .din(din), .dout(dout)
    );

    always #2 clk = ~clk;

    int n_checks = 0, n_fail = 0;

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [11:0] model_val(input logic [7:0] b);
        if (b[3]) return {4'h0, b ^ 8'h3C};
        return {b, b[3:0] ^ 4'h9};
    endfunction

    // Converter model
    int          g_rise = 0, n_starts = 0, m_k = 0, m_out = 0, frames = 0, last_len = 0;
    int          n_bytes = 0, setup_cyc = 0;
    int          start_pos [0:3];
    bit          m_act = 0, m_n8 = 0, first_seen = 0;
    logic [7:0]  m_sh = 0, m_byte = 0;
    logic [11:0] m_val = 0;
    time         t_cs = 0;

    always @(negedge cs_n) begin
        g_rise = 0; n_starts = 0; m_k = 0; m_act = 0;
        frames++; t_cs = $time; first_seen = 0;
    end

    always @(posedge cs_n) last_len = g_rise;

    always @(posedge dclk) begin
        if (!first_seen) begin
            setup_cyc  = int'(($time - t_cs) / 4);
            first_seen = 1;
        end
        g_rise++;
        if (m_act) m_out++;
        if (m_k == 0) begin
            if (din === 1'b1) begin
                m_k  = 1;
                m_sh = 8'h01;
                if (n_starts < 4) start_pos[n_starts] = g_rise;
                n_starts++;
            end
        end else begin
            m_sh = {m_sh[6:0], din};
            m_k++;
            if (m_k == 8) begin
                m_byte = m_sh; m_n8 = m_sh[3]; m_val = model_val(m_sh);
                m_out = 0; m_act = 1; m_k = 0; n_bytes++;
            end
        end
    end

    always @(negedge dclk) begin
        int len;
        len = m_n8 ? 8 : 12;
        if (m_act && m_out >= 1 && m_out <= len) dout = m_val[len - m_out];
        else dout = 1'b0;
    end

    task automatic issue(input logic [6:0] v);
        @(negedge clk);
        {chan, narrow, ref_single, pd} = v;
        req = 1;
        @(negedge clk);
        req = 0;
    endtask

    task automatic wait_done(output logic [11:0] r);
        do @(posedge clk); while (done !== 1'b1);
        #1 r = result;
    endtask

    task automatic wait_idle();
        do @(posedge clk); while (busy !== 1'b0);
        repeat (4) @(negedge clk);
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    endtask

    initial begin
        #(200000 * 4);
        n_checks++; n_fail++;
        $display("FAIL watchdog R1..R9 actual=hung expected=finished");
        finish_run();
    end

    initial begin
        logic [11:0] r, r2;
        logic [7:0]  eb;
        int          f0, nb;

        // R9: reset state
        repeat (5) @(negedge clk);
        check("R9 cs_n", cs_n, 1);
        check("R9 dclk", dclk, 0);
        check("R9 din", din, 0);
        check("R9 busy", busy, 0);
        check("R9 done", done, 0);
        rst_n = 1;
        repeat (3) @(negedge clk);

        // Standard frames from the vector table
        for (int i = 0; i < 6; i++) begin
            eb = {1'b1, VEC[i]};
            issue(VEC[i]);
            check("R6 busy after request", busy, 1);
            wait_done(r);
            check("R1 command byte", m_byte, eb);
            if (eb[3]) begin
                check("R5 narrow result", r, model_val(eb));
                check("R5 upper bits zero", r[11:8], 0);
            end else begin
                check("R4 wide result", r, model_val(eb));
            end
            wait_idle();
            check("R3 frame length", last_len, 24);
            if (i == 0) check("R2 chip-select setup", setup_cyc, HALF);
        end

        // R6: request while busy without overlap is ignored
        f0 = frames;
        issue(7'b010_0_1_10);
        issue(7'b100_1_0_01);
        wait_done(r);
        check("R6 first result kept", r, model_val(8'b1_010_0_1_10));
        wait_idle();
        repeat (80) @(negedge clk);
        check("R6 second request dropped", frames, f0 + 1);
        check("R6 idle after frame", busy, 0);

        // R7/R8: overlapped 12-bit pair, third request dropped
        overlap_en = 1;
        f0 = frames; nb = n_bytes;
        issue(7'b011_0_0_00);
        do @(posedge clk); while (cs_n !== 1'b0);
        issue(7'b101_0_1_11);
        issue(7'b111_1_1_01);
        wait_done(r);
        wait_done(r2);
        wait_idle();
        repeat (80) @(negedge clk);
        check("R8 wide first result", r, model_val(8'b1_011_0_0_00));
        check("R8 wide second result", r2, model_val(8'b1_101_0_1_11));
        check("R8 wide start spacing", start_pos[1] - start_pos[0], 15);
        check("R8 wide window length", last_len, 39);
        check("R8 single chip-select window", frames, f0 + 1);
        check("R7 third request dropped", n_bytes, nb + 2);

        // R7/R8: overlapped 8-bit pair
        f0 = frames; nb = n_bytes;
        issue(7'b001_1_0_11);
        do @(posedge clk); while (cs_n !== 1'b0);
        issue(7'b110_1_1_00);
        wait_done(r);
        wait_done(r2);
        wait_idle();
        check("R8 narrow first result", r, model_val(8'b1_001_1_0_11));
        check("R8 narrow second result", r2, model_val(8'b1_110_1_1_00));
        check("R5 narrow upper zero", r2[11:8], 0);
        check("R8 narrow start spacing", start_pos[1] - start_pos[0], 11);
        check("R8 narrow window length", last_len, 35);
        check("R7 both commands sent", n_bytes, nb + 2);

        finish_run();
    end

endmodule